// File: doc/BRIEF.md
# One-Time-Programmable Memory Burn Sequencer

This block burns a byte-wide one-time-programmable memory using a fast, interactive pulse-and-check method. After a start request it raises the target's supply to the programming level and walks the addresses in ascending order from zero. At each address it fetches the desired byte from a data source port. It applies high-voltage program pulses on the active-low chip enable, and after each pulse it reads the byte back. It stops pulsing that address as soon as the read-back matches. If the match never comes within a bounded number of pulses, it stops and reports a failure.

When every address has been written, the supply select drops to the lower verify level and the whole array is read once more and compared against the source. The result is reported on a done/pass/fail handshake, together with the failing address and the number of pulses spent there. Pulse width, setup, hold, recovery, read delay and supply settle times are parameters counted in clock cycles. A start-time input picks the short or the long pulse width.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is high, and in the cycle after it, the chip enable and output enable are high (inactive), high voltage is off, and done, pass and fail are 0.
- R2: A program pulse (chip enable low while high voltage is on) occurs only with the programming supply level selected and the data driver enabled. Address and data stay constant through the pulse and for at least SETUP_CYC cycles before it and HOLD_CYC cycles after it.
- R3: Every program pulse lasts exactly PW_LONG cycles when pulse_long was 1 at the accepted start, and PW_SHORT cycles when it was 0.
- R4: Every pulse is followed by a read-back with output enable and chip enable low and high voltage off. Data is compared VERIFY_CYC cycles after chip enable falls.
- R5: At one address, pulses repeat until the read-back equals the source byte. If MAX_PULSES (25) pulses have been applied and the read-back still differs, the run ends with fail=1, fail_addr at that address and fail_pulses=25.
- R6: A source byte of all ones (8'hFF) gets no pulse but is still read back. A mismatch on such a byte ends the run with fail=1 and fail_pulses=0.
- R7: Addresses are programmed in ascending order from 0 to 2^ADDR_W-1. Each pulse drives the source byte of the current address on tgt_dout.
- R8: After the last address, the supply select goes low (verify level) and every address is read in ascending order. The first mismatch ends the run with fail=1, fail_addr at that address and fail_pulses=0. If there is no mismatch, the run ends with pass=1.
- R9: When a run ends, done rises with exactly one of pass and fail set. done, pass, fail and the reported fields hold while start stays high, and done falls one cycle after start is seen low.
- R10: High voltage must have been off for at least RECOVER_CYC cycles before output enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request; hold high until done, then drop |
| pulse_long | input | 1 | Pulse width select, sampled at start (1 = long) |
| done | output | 1 | Run finished |
| pass | output | 1 | Whole array programmed and verified |
| fail | output | 1 | Run aborted on a failure |
| fail_addr | output | ADDR_W | Address of the failure |
| fail_pulses | output | $clog2(MAX_PULSES+1) | Pulses applied at the failing address |
| src_addr | output | ADDR_W | Address into the data source |
| src_data | input | DATA_W | Desired byte for src_addr |
| tgt_addr | output | ADDR_W | Target address |
| tgt_dout | output | DATA_W | Data toward the target |
| tgt_dout_en | output | 1 | Drive enable for tgt_dout |
| tgt_din | input | DATA_W | Data read from the target |
| tgt_ce_n | output | 1 | Target chip enable, active low; also the program pulse |
| tgt_oe_n | output | 1 | Target output enable, active low |
| tgt_hv_en | output | 1 | Raise the shared output-enable line to programming voltage |
| tgt_supply_hi | output | 1 | 1 = programming supply level, 0 = verify level |

## Verification
The bench drives the sequencer against a behavioural target in which every address needs its own number of pulses before it takes the data. One run mixes one-, two- and three-pulse addresses with all-ones bytes under short pulses. A second run uses long pulses with a different pulse profile, which separates the retry count from the width selection. Three fault patterns follow. A stuck address tells the pulse limit apart from a normal retry. A cell that reads wrong only at the low supply shows that the final pass really runs at the verify level. A pre-cleared bit under an all-ones byte shows that such a byte is checked yet never pulsed.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_LOAD,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RECOVER,
        ST_CHECK,
        ST_FV_SETTLE,
        ST_FV_READ,
        ST_FV_GAP,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic hv_en;
        logic supply_hi;
        logic dout_en;
    } pins_t;

    // Target pin levels as a pure function of the sequencer state.
    function automatic pins_t pins_of(seq_state_e s);
        pins_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, hv_en: 1'b0, supply_hi: 1'b0, dout_en: 1'b0};
        case (s)
            ST_SETTLE, ST_LOAD, ST_RECOVER: p.supply_hi = 1'b1;
            ST_SETUP, ST_HOLD: begin
                p.supply_hi = 1'b1;
                p.hv_en     = 1'b1;
                p.dout_en   = 1'b1;
            end
            ST_PULSE: begin
                p.supply_hi = 1'b1;
                p.hv_en     = 1'b1;
                p.dout_en   = 1'b1;
                p.ce_n      = 1'b0;
            end
            ST_CHECK: begin
                p.supply_hi = 1'b1;
                p.ce_n      = 1'b0;
                p.oe_n      = 1'b0;
            end
            ST_FV_READ: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            default: ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/otp_wait_timer.sv
module otp_wait_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/otp_step_ctr.sv
module otp_step_ctr #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            q <= '0;
        else if (inc)
            q <= q + 1'b1;
    end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_prog_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned MAX_PULSES  = 25,
    parameter int unsigned PW_SHORT    = 2,
    parameter int unsigned PW_LONG     = 6,
    parameter int unsigned SETUP_CYC   = 2,
    parameter int unsigned HOLD_CYC    = 2,
    parameter int unsigned RECOVER_CYC = 3,
    parameter int unsigned VERIFY_CYC  = 2,
    parameter int unsigned SETTLE_CYC  = 4,
    localparam int unsigned CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pulse_long,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [CNT_W-1:0]  fail_pulses,
    output logic [ADDR_W-1:0] src_addr,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_dout,
    output logic              tgt_dout_en,
    input  logic [DATA_W-1:0] tgt_din,
    output logic              tgt_ce_n,
    output logic              tgt_oe_n,
    output logic              tgt_hv_en,
    output logic              tgt_supply_hi
);
    localparam int unsigned LAST_ADDR = (1 << ADDR_W) - 1;
    localparam int unsigned TMR_W = $clog2(PW_LONG + PW_SHORT + SETUP_CYC + HOLD_CYC
                                           + RECOVER_CYC + VERIFY_CYC + SETTLE_CYC + 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] word_q;
    logic              long_q;

    logic              addr_clr, addr_inc, cnt_clr, cnt_inc;
    logic              accept, load_word, set_pass, set_fail;
    logic [CNT_W-1:0]  rep_cnt_d;
    logic              tmr_zero, tmr_load;
    logic [TMR_W-1:0]  tmr_val;

    logic              pass_q, fail_q;
    logic [ADDR_W-1:0] rep_addr_q;
    logic [CNT_W-1:0]  rep_cnt_q;
    pins_t             pins;

    // Residence time of each state, minus one, as loaded into the timer.
    function automatic logic [TMR_W-1:0] stay_of(seq_state_e s, logic lng);
        int unsigned n;
        case (s)
            ST_SETTLE, ST_FV_SETTLE: n = SETTLE_CYC;
            ST_SETUP:                n = SETUP_CYC;
            ST_PULSE:                n = lng ? PW_LONG : PW_SHORT;
            ST_HOLD:                 n = HOLD_CYC;
            ST_RECOVER:              n = RECOVER_CYC;
            ST_CHECK, ST_FV_READ:    n = VERIFY_CYC;
            default:                 n = 1;
        endcase
        return TMR_W'(n - 1);
    endfunction

    otp_step_ctr #(.W(ADDR_W)) u_addr (
        .clk (clk), .rst (rst), .clr (addr_clr), .inc (addr_inc), .q (addr_q)
    );

    otp_step_ctr #(.W(CNT_W)) u_pulses (
        .clk (clk), .rst (rst), .clr (cnt_clr), .inc (cnt_inc), .q (cnt_q)
    );

    otp_wait_timer #(.W(TMR_W)) u_timer (
        .clk (clk), .rst (rst), .load (tmr_load), .val (tmr_val), .zero (tmr_zero)
    );

    logic at_last, word_match, word_ones, src_ones, cnt_full, final_match;
    assign at_last     = (addr_q == ADDR_W'(LAST_ADDR));
    assign word_match  = (tgt_din == word_q);
    assign word_ones   = &word_q;
    assign src_ones    = &src_data;
    assign cnt_full    = (cnt_q == CNT_W'(MAX_PULSES));
    assign final_match = (tgt_din == src_data);

    always_comb begin
        state_d   = state_q;
        addr_clr  = 1'b0;
        addr_inc  = 1'b0;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        accept    = 1'b0;
        load_word = 1'b0;
        set_pass  = 1'b0;
        set_fail  = 1'b0;
        rep_cnt_d = '0;
        case (state_q)
            ST_IDLE: if (start) begin
                accept   = 1'b1;
                addr_clr = 1'b1;
                cnt_clr  = 1'b1;
                state_d  = ST_SETTLE;
            end
            ST_SETTLE:  if (tmr_zero) state_d = ST_LOAD;
            ST_LOAD: begin
                load_word = 1'b1;
                state_d   = src_ones ? ST_CHECK : ST_SETUP;
            end
            ST_SETUP:   if (tmr_zero) state_d = ST_PULSE;
            ST_PULSE: if (tmr_zero) begin
                cnt_inc = 1'b1;
                state_d = ST_HOLD;
            end
            ST_HOLD:    if (tmr_zero) state_d = ST_RECOVER;
            ST_RECOVER: if (tmr_zero) state_d = ST_CHECK;
            ST_CHECK: if (tmr_zero) begin
                if (word_match) begin
                    cnt_clr = 1'b1;
                    if (at_last) begin
                        addr_clr = 1'b1;
                        state_d  = ST_FV_SETTLE;
                    end else begin
                        addr_inc = 1'b1;
                        state_d  = ST_LOAD;
                    end
                end else if (word_ones || cnt_full) begin
                    set_fail  = 1'b1;
                    rep_cnt_d = cnt_q;
                    state_d   = ST_DONE;
                end else begin
                    state_d = ST_SETUP;
                end
            end
            ST_FV_SETTLE: if (tmr_zero) state_d = ST_FV_READ;
            ST_FV_READ: if (tmr_zero) begin
                if (final_match) begin
                    state_d = ST_FV_GAP;
                end else begin
                    set_fail = 1'b1;
                    state_d  = ST_DONE;
                end
            end
            ST_FV_GAP: begin
                if (at_last) begin
                    set_pass = 1'b1;
                    state_d  = ST_DONE;
                end else begin
                    addr_inc = 1'b1;
                    state_d  = ST_FV_READ;
                end
            end
            ST_DONE:    if (!start) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign tmr_load = (state_d != state_q);
    assign tmr_val  = stay_of(state_d, long_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            word_q     <= '1;
            long_q     <= 1'b0;
            pass_q     <= 1'b0;
            fail_q     <= 1'b0;
            rep_addr_q <= '0;
            rep_cnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_word)
                word_q <= src_data;
            if (accept) begin
                long_q     <= pulse_long;
                pass_q     <= 1'b0;
                fail_q     <= 1'b0;
                rep_addr_q <= '0;
                rep_cnt_q  <= '0;
            end
            if (set_pass)
                pass_q <= 1'b1;
            if (set_fail) begin
                fail_q     <= 1'b1;
                rep_addr_q <= addr_q;
                rep_cnt_q  <= rep_cnt_d;
            end
        end
    end

    assign pins          = pins_of(state_q);
    assign tgt_ce_n      = pins.ce_n;
    assign tgt_oe_n      = pins.oe_n;
    assign tgt_hv_en     = pins.hv_en;
    assign tgt_supply_hi = pins.supply_hi;
    assign tgt_dout_en   = pins.dout_en;
    assign tgt_dout      = word_q;
    assign tgt_addr      = addr_q;
    assign src_addr      = addr_q;

    assign done        = (state_q == ST_DONE);
    assign pass        = pass_q;
    assign fail        = fail_q;
    assign fail_addr   = rep_addr_q;
    assign fail_pulses = rep_cnt_q;
endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk #(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned MAX_PULSES  = 25,
    parameter int unsigned PW_SHORT    = 2,
    parameter int unsigned PW_LONG     = 6,
    parameter int unsigned RECOVER_CYC = 3,
    localparam int unsigned CNT_W      = $clog2(MAX_PULSES + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              pass,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [CNT_W-1:0]  fail_pulses,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [DATA_W-1:0] tgt_dout,
    input logic              tgt_dout_en,
    input logic              tgt_ce_n,
    input logic              tgt_oe_n,
    input logic              tgt_hv_en,
    input logic              tgt_supply_hi
);
    localparam int unsigned WL_W  = $clog2(PW_LONG + PW_SHORT + 2);
    localparam int unsigned REC_W = $clog2(RECOVER_CYC + 2);

    logic [WL_W-1:0]  low_len;
    logic [REC_W-1:0] off_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_len <= '0;
            off_len <= REC_W'(RECOVER_CYC);
        end else begin
            if (!tgt_ce_n && tgt_hv_en)
                low_len <= low_len + 1'b1;
            else
                low_len <= '0;
            if (tgt_hv_en)
                off_len <= '0;
            else if (off_len < REC_W'(RECOVER_CYC))
                off_len <= off_len + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (tgt_ce_n && tgt_oe_n && !tgt_hv_en && !done && !pass && !fail));

    assert_hv_context_R2: assert property (@(posedge clk) disable iff (rst)
        tgt_hv_en |-> (tgt_supply_hi && tgt_dout_en));

    assert_pulse_stable_R2: assert property (@(posedge clk) disable iff (rst)
        (tgt_hv_en && $past(tgt_hv_en)) |-> ($stable(tgt_addr) && $stable(tgt_dout)));

    assert_pulse_width_R3: assert property (@(posedge clk) disable iff (rst)
        (tgt_ce_n && $past(!tgt_ce_n && tgt_hv_en)) |->
            (low_len == WL_W'(PW_SHORT) || low_len == WL_W'(PW_LONG)));

    assert_read_no_hv_R4: assert property (@(posedge clk) disable iff (rst)
        !tgt_oe_n |-> (!tgt_hv_en && !tgt_dout_en && !tgt_ce_n));

    assert_pulse_limit_R5: assert property (@(posedge clk) disable iff (rst)
        fail_pulses <= CNT_W'(MAX_PULSES));

    assert_result_excl_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass ^ fail));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> (done && $stable(pass) && $stable(fail)
                             && $stable(fail_addr) && $stable(fail_pulses)));

    assert_recover_R10: assert property (@(posedge clk) disable iff (rst)
        !tgt_oe_n |-> (off_len >= REC_W'(RECOVER_CYC)));
endmodule

bind otp_prog_seq otp_prog_seq_chk #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .MAX_PULSES  (MAX_PULSES),
    .PW_SHORT    (PW_SHORT),
    .PW_LONG     (PW_LONG),
    .RECOVER_CYC (RECOVER_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .done          (done),
    .pass          (pass),
    .fail          (fail),
    .fail_addr     (fail_addr),
    .fail_pulses   (fail_pulses),
    .tgt_addr      (tgt_addr),
    .tgt_dout      (tgt_dout),
    .tgt_dout_en   (tgt_dout_en),
    .tgt_ce_n      (tgt_ce_n),
    .tgt_oe_n      (tgt_oe_n),
    .tgt_hv_en     (tgt_hv_en),
    .tgt_supply_hi (tgt_supply_hi)
);

// File: tb/tb_otp_prog_seq.sv
`timescale 1ns/1ps
module tb_otp_prog_seq;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int MAXP  = 25;
    localparam int PWS   = 2;
    localparam int PWL   = 6;
    localparam int CW    = $clog2(MAXP + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic pulse_long = 1'b0;
    logic done, pass, fail;
    logic [AW-1:0] fail_addr, src_addr, tgt_addr;
    logic [CW-1:0] fail_pulses;
    logic [DW-1:0] src_data, tgt_dout, tgt_din;
    logic tgt_dout_en, tgt_ce_n, tgt_oe_n, tgt_hv_en, tgt_supply_hi;

    always #2.5 clk = ~clk;

    otp_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .MAX_PULSES(MAXP), .PW_SHORT(PWS), .PW_LONG(PWL),
        .SETUP_CYC(2), .HOLD_CYC(2), .RECOVER_CYC(3), .VERIFY_CYC(2), .SETTLE_CYC(4)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .pulse_long(pulse_long),
        .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
        .fail_pulses(fail_pulses), .src_addr(src_addr), .src_data(src_data),
        .tgt_addr(tgt_addr), .tgt_dout(tgt_dout), .tgt_dout_en(tgt_dout_en),
        .tgt_din(tgt_din), .tgt_ce_n(tgt_ce_n), .tgt_oe_n(tgt_oe_n),
        .tgt_hv_en(tgt_hv_en), .tgt_supply_hi(tgt_supply_hi)
    );

    // Target model and data source
    logic [DW-1:0] mem      [DEPTH];
    logic [DW-1:0] data_arr [DEPTH];
    int            need     [DEPTH];
    int            pcount   [DEPTH];
    int            weak_a = -1;

    always_comb src_data = data_arr[src_addr];

    always_comb begin
        tgt_din = '1;
        if (!tgt_ce_n && !tgt_oe_n && !tgt_hv_en) begin
            tgt_din = mem[tgt_addr];
            if (!tgt_supply_hi && int'(tgt_addr) == weak_a)
                tgt_din = tgt_din ^ 8'h01;
        end
    end

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard: expected pulses as {addr, data}
    logic [AW+DW-1:0] exp_q[$];
    int exp_width = PWS;
    int fin_reads = 0;
    int low_cnt = 0;
    logic prev_ce = 1'b1;
    logic prev_hv = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            prev_ce = 1'b1;
            prev_hv = 1'b0;
        end else begin
            if (prev_ce && !tgt_ce_n && tgt_hv_en) begin
                logic [AW+DW-1:0] item;
                if (exp_q.size() == 0) begin
                    chk(0, "R5", "unexpected pulse at addr", int'(tgt_addr), -1);
                end else begin
                    item = exp_q.pop_front();
                    chk(item[AW+DW-1:DW] == tgt_addr, "R7", "pulse address",
                        int'(tgt_addr), int'(item[AW+DW-1:DW]));
                    chk(item[DW-1:0] == tgt_dout, "R7", "pulse data",
                        int'(tgt_dout), int'(item[DW-1:0]));
                end
                chk(tgt_supply_hi && tgt_dout_en, "R2", "pulse supply/drive",
                    int'({tgt_supply_hi, tgt_dout_en}), 3);
                pcount[tgt_addr]++;
                if (pcount[tgt_addr] >= need[tgt_addr])
                    mem[tgt_addr] = mem[tgt_addr] & tgt_dout;
                low_cnt = 1;
            end else if (!tgt_ce_n && tgt_hv_en) begin
                low_cnt++;
            end
            if (!prev_ce && tgt_ce_n && prev_hv)
                chk(low_cnt == exp_width, "R3", "pulse width", low_cnt, exp_width);
            if (prev_ce && !tgt_ce_n && !tgt_hv_en && !tgt_supply_hi && !tgt_oe_n)
                fin_reads++;
            prev_ce = tgt_ce_n;
            prev_hv = tgt_hv_en;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Driver: set up the target, push the expected pulses, run, compare result.
    task automatic run_case(input string name, input bit plong, input int mode,
                            input int stuck_a, input int weak_in,
                            input int preset_a, input logic [DW-1:0] preset_v);
        bit exp_pass;
        int exp_fa, exp_fp, exp_fin, wd;
        bit stop;
        exp_q.delete();
        fin_reads = 0;
        weak_a    = weak_in;
        exp_width = plong ? PWL : PWS;
        for (int a = 0; a < DEPTH; a++) begin
            mem[a]    = '1;
            pcount[a] = 0;
            if (mode == 0) begin
                data_arr[a] = DW'((a * 17) ^ 8'h5A);
                need[a]     = (a % 3) + 1;
            end else begin
                data_arr[a] = DW'(~(a << 3) ^ (a * 5));
                need[a]     = ((a * 5) % 4) + 1;
            end
            if (a == stuck_a) need[a] = 99;
        end
        if (mode == 0) begin
            data_arr[2] = '1;
            data_arr[7] = '1;
        end else begin
            data_arr[4] = '0;
        end
        if (preset_a >= 0) begin
            data_arr[preset_a] = '1;
            mem[preset_a]      = preset_v;
        end
        exp_pass = 1; exp_fa = 0; exp_fp = 0; stop = 0;
        for (int a = 0; a < DEPTH && !stop; a++) begin
            if (data_arr[a] == '1) begin
                if (mem[a] != '1) begin
                    exp_pass = 0; exp_fa = a; exp_fp = 0; stop = 1;
                end
            end else if (need[a] > MAXP) begin
                for (int k = 0; k < MAXP; k++) exp_q.push_back({AW'(a), data_arr[a]});
                exp_pass = 0; exp_fa = a; exp_fp = MAXP; stop = 1;
            end else begin
                for (int k = 0; k < need[a]; k++) exp_q.push_back({AW'(a), data_arr[a]});
            end
        end
        exp_fin = 0;
        if (!stop) begin
            if (weak_in >= 0) begin
                exp_pass = 0; exp_fa = weak_in; exp_fp = 0; exp_fin = weak_in + 1;
            end else begin
                exp_fin = DEPTH;
            end
        end
        @(negedge clk);
        pulse_long = plong;
        start      = 1'b1;
        wd = 0;
        while (!done && wd < 20000) begin
            @(negedge clk);
            wd++;
        end
        chk(done == 1'b1, "R9", {name, " watchdog/done"}, int'(done), 1);
        chk(pass == exp_pass && fail == !exp_pass, exp_pass ? "R8" : "R5",
            {name, " pass/fail"}, int'({pass, fail}), exp_pass ? 2 : 1);
        if (!exp_pass) begin
            chk(int'(fail_addr) == exp_fa, "R5", {name, " fail_addr"}, int'(fail_addr), exp_fa);
            chk(int'(fail_pulses) == exp_fp, "R6", {name, " fail_pulses"},
                int'(fail_pulses), exp_fp);
        end
        chk(exp_q.size() == 0, "R5", {name, " pulses left unissued"}, exp_q.size(), 0);
        chk(fin_reads == exp_fin, "R8", {name, " low-supply reads"}, fin_reads, exp_fin);
        repeat (3) @(negedge clk);
        chk(done && pass == exp_pass && fail == !exp_pass, "R9", {name, " result held"},
            int'({done, pass, fail}), exp_pass ? 6 : 5);
        start = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R9", {name, " done falls"}, int'(done), 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tgt_ce_n && tgt_oe_n && !tgt_hv_en && !done && !pass && !fail, "R1",
            "reset state", int'({tgt_ce_n, tgt_oe_n, tgt_hv_en, done, pass, fail}), 6'b110000);
        rst = 1'b0;
        @(negedge clk);
        chk(tgt_ce_n && !tgt_hv_en && !done, "R1", "idle after reset",
            int'({tgt_ce_n, tgt_hv_en, done}), 3'b100);
        // R3 R5 R6 R7 R8: mixed retries, all-ones bytes, short pulses
        run_case("short_mix", 1'b0, 0, -1, -1, -1, '1);
        // R3 R5 R7 R8: long pulses, other profile
        run_case("long_mix", 1'b1, 1, -1, -1, -1, '1);
        // R5: stuck address hits the pulse limit
        run_case("stuck", 1'b0, 0, 5, -1, -1, '1);
        // R8: cell wrong only at the verify supply level
        run_case("weak_low", 1'b1, 1, -1, 9, -1, '1);
        // R6: all-ones byte over a pre-cleared bit, no pulse, count 0
        run_case("preset_ones", 1'b0, 0, -1, -1, 3, 8'h7F);
        finish_run();
    end

    initial begin
        #(200000 * 5);
        chk(0, "R9", "global watchdog", 0, 1);
        finish_run();
    end
endmodule